// File: doc/BRIEF.md
# Two-way translation lookaside buffer

This block caches virtual-to-physical page translations for a 32-bit address space with 4 KB pages. It holds two arrays, one for instruction fetches and one for data accesses. Each array is a set of two-way sets with one recency bit per set. Each way keeps a tag, a physical page number and a copy of the low page-table-entry word.

A lookup presents an effective address and an access kind. One cycle later the block returns a hit, a miss or a "changed bit needs updating" indication. A hit also returns the physical address and a flag that tells whether the page is write-through or cache-inhibited.

After a page-table search, the walker loads the translated entry through a refill port. The walker also supplies the access kind, and accesses marked no-exception never install an entry. Hashing, the memory walk and exception generation sit outside this block.

Top module: `tlb2w_top`

## Requirements
- R1: After reset all response outputs are 0 and every way of both arrays is invalid, so every lookup misses.
- R2: The response is registered. `rsp_valid` is 1 exactly one cycle after `req_valid` and 0 otherwise. `rsp_hit` is 1 when the virtual page number `req_addr[31:12]` equals the tag of a valid way in set `req_addr[12+SETS_LOG2-1:12]` of the selected array. When no request is made, the other response outputs hold their values.
- R3: On a hit, `rsp_paddr` is {PTE[31:12] of the installed entry, `req_addr[11:0]`}. When the response is not a hit, `rsp_paddr` is 0.
- R4: Access kind 2 (fetch) uses the instruction array. Kinds 0 (read), 1 (write) and 3 (treated as read) use the data array. An entry installed in one array is never seen by the other.
- R5: A write (kind 1, `req_noexc`=0) that hits an entry whose C bit (PTE bit 7) is 0 responds with `rsp_upd_c`=1, `rsp_hit`=0, `rsp_paddr`=0 and `rsp_wi`=0. It sets C in the stored word and leaves the recency bit unchanged, so the next write to that page is a normal hit. Reads and fetches never set C.
- R6: On a hit, `rsp_wi` is PTE bit 6 OR PTE bit 5. When the response is not a hit, `rsp_wi` is 0.
- R7: A hit in way 0 sets the set's recency bit to 0, and a hit in way 1 sets it to 1. A refill writes way 1 when the recency bit is 0 and way 0 is valid; otherwise it writes way 0. The recency bit then takes the index of the way written.
- R8: A refill with `fill_noexc`=1 changes nothing. A write lookup with `req_noexc`=1 never sets C and reports a normal hit.
- R9: A refill is dropped while `rsp_upd_c` is 1.
- R10: A refill and a lookup in the same cycle, to the same set of the same array, give the refill priority: the refill is installed and the lookup reports a miss. If they target different sets or different arrays, both take effect.
- R11: `flush` invalidates every way of both arrays in one cycle. A lookup in the flush cycle reports a miss, and a refill in the flush cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries |
| req_valid | input | 1 | Lookup request |
| req_addr | input | 32 | Effective address to translate |
| req_op | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 read |
| req_noexc | input | 1 | Lookup is of the no-exception kind |
| fill_valid | input | 1 | Refill request |
| fill_vpn | input | 20 | Virtual page number of the refilled page |
| fill_op | input | 2 | Access kind of the refill (selects the array) |
| fill_noexc | input | 1 | Refill belongs to a no-exception access |
| fill_pte | input | 32 | Low page-table-entry word to install |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation found |
| rsp_upd_c | output | 1 | Hit needed a changed-bit update |
| rsp_paddr | output | 32 | Physical address |
| rsp_wi | output | 1 | Write-through or cache-inhibited page |

## Verification
The bench builds the block with SETS_LOG2=2, so each array has four sets. With only four sets, a sweep over a small page range fills every way of both arrays and forces repeated evictions in every set. It also creates frequent same-set clashes between refills and lookups. A bench-side reference model tracks tags, PTE words, recency bits and the last changed-bit result. A long pseudo-random mix of lookups, refills of both kinds and flushes then reaches every combination of way state, recency bit and C bit.

// File: rtl/tlb2w_pkg.sv
package tlb2w_pkg;

    localparam logic [1:0] OP_READ  = 2'd0;
    localparam logic [1:0] OP_WRITE = 2'd1;
    localparam logic [1:0] OP_FETCH = 2'd2;

    localparam int PTE_W  = 32;
    localparam int C_BIT  = 7;
    localparam int WT_BIT = 6;
    localparam int CI_BIT = 5;

    // way to overwrite on refill
    function automatic logic pick_victim(input logic recent, input logic way0_valid);
        return (!recent) && way0_valid;
    endfunction

endpackage

// File: rtl/tlb2w_way_match.sv
module tlb2w_way_match #(
    parameter int TAG_W = 20
) (
    input  logic [TAG_W-1:0] tag0,
    input  logic [TAG_W-1:0] tag1,
    input  logic [TAG_W-1:0] probe,
    output logic             hit,
    output logic             way
);
    logic m0, m1;

    always_comb begin
        m0  = (tag0 == probe) && (tag0 != '1);
        m1  = (tag1 == probe) && (tag1 != '1);
        hit = m0 || m1;
        way = !m0;
    end
endmodule

// File: rtl/tlb2w_array.sv
module tlb2w_array
    import tlb2w_pkg::*;
#(
    parameter int SETS_LOG2 = 4,
    parameter int TAG_W     = 20,
    parameter int PPN_W     = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush,
    input  logic                 lk_en,
    input  logic [SETS_LOG2-1:0] lk_set,
    input  logic [TAG_W-1:0]     lk_tag,
    input  logic                 lk_c_ok,
    output logic                 lk_hit,
    output logic                 lk_cneed,
    output logic [PPN_W-1:0]     lk_ppn,
    output logic                 lk_wi,
    input  logic                 fill_en,
    input  logic [SETS_LOG2-1:0] fill_set,
    input  logic [TAG_W-1:0]     fill_tag,
    input  logic [PTE_W-1:0]     fill_pte
);
    localparam int SETS = 1 << SETS_LOG2;

    typedef struct packed {
        logic [SETS-1:0][1:0][TAG_W-1:0] tag;
        logic [SETS-1:0][1:0][PPN_W-1:0] ppn;
        logic [SETS-1:0][1:0][PTE_W-1:0] pte;
        logic [SETS-1:0]                 recent;
    } arr_t;

    arr_t st_d, st_q;
    logic way;
    logic victim;

    tlb2w_way_match #(.TAG_W(TAG_W)) u_match (
        .tag0  (st_q.tag[lk_set][0]),
        .tag1  (st_q.tag[lk_set][1]),
        .probe (lk_tag),
        .hit   (lk_hit),
        .way   (way)
    );

    assign lk_ppn   = st_q.ppn[lk_set][way];
    assign lk_wi    = st_q.pte[lk_set][way][WT_BIT] | st_q.pte[lk_set][way][CI_BIT];
    assign lk_cneed = lk_hit && lk_c_ok && !st_q.pte[lk_set][way][C_BIT];

    always_comb begin
        st_d   = st_q;
        victim = pick_victim(st_q.recent[fill_set], st_q.tag[fill_set][0] != '1);
        if (flush) begin
            st_d.tag = '1;
        end else begin
            if (lk_en && lk_hit) begin
                if (lk_cneed) st_d.pte[lk_set][way][C_BIT] = 1'b1;
                else          st_d.recent[lk_set]          = way;
            end
            if (fill_en) begin
                st_d.tag[fill_set][victim] = fill_tag;
                st_d.ppn[fill_set][victim] = fill_pte[PTE_W-1 -: PPN_W];
                st_d.pte[fill_set][victim] = fill_pte;
                st_d.recent[fill_set]      = victim;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.tag    <= '1;
            st_q.ppn    <= '0;
            st_q.pte    <= '0;
            st_q.recent <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assert_flush_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (st_q.tag == '1));

    assert_tags_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!fill_en && !flush) |=> $stable(st_q.tag));

    assert_c_marked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_en && lk_cneed && !flush) |=> st_q.pte[$past(lk_set)][$past(way)][C_BIT]);

    assert_victim_way1_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !flush && !st_q.recent[fill_set] && st_q.tag[fill_set][0] != '1)
        |=> (st_q.tag[$past(fill_set)][1] == $past(fill_tag)));
endmodule

// File: rtl/tlb2w_top.sv
module tlb2w_top
    import tlb2w_pkg::*;
#(
    parameter int VA_W       = 32,
    parameter int PAGE_SHIFT = 12,
    parameter int SETS_LOG2  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic                     req_valid,
    input  logic [VA_W-1:0]          req_addr,
    input  logic [1:0]               req_op,
    input  logic                     req_noexc,
    input  logic                     fill_valid,
    input  logic [VA_W-PAGE_SHIFT-1:0] fill_vpn,
    input  logic [1:0]               fill_op,
    input  logic                     fill_noexc,
    input  logic [PTE_W-1:0]         fill_pte,
    output logic                     rsp_valid,
    output logic                     rsp_hit,
    output logic                     rsp_upd_c,
    output logic [VA_W-1:0]          rsp_paddr,
    output logic                     rsp_wi
);
    localparam int TAG_W = VA_W - PAGE_SHIFT;
    localparam int PPN_W = TAG_W;

    typedef struct packed {
        logic            valid;
        logic            hit;
        logic            updc;
        logic [VA_W-1:0] paddr;
        logic            wi;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    logic [TAG_W-1:0]     req_vpn;
    logic [SETS_LOG2-1:0] req_set, fill_set;
    logic                 req_side, fill_side;
    logic                 fill_go, clash, lk_go, c_ok;
    logic [1:0]           arr_hit, arr_cneed, arr_wi;
    logic [1:0][PPN_W-1:0] arr_ppn;
    logic                 sel_hit, sel_cneed;

    always_comb begin
        req_vpn   = req_addr[VA_W-1:PAGE_SHIFT];
        req_set   = req_vpn[SETS_LOG2-1:0];
        fill_set  = fill_vpn[SETS_LOG2-1:0];
        req_side  = (req_op == OP_FETCH);
        fill_side = (fill_op == OP_FETCH);
        fill_go   = fill_valid && !fill_noexc && !rsp_q.updc && !flush;
        clash     = fill_go && (fill_side == req_side) && (fill_set == req_set);
        lk_go     = req_valid && !flush && !clash;
        c_ok      = (req_op == OP_WRITE) && !req_noexc;
    end

    for (genvar g = 0; g < 2; g++) begin : g_side
        tlb2w_array #(
            .SETS_LOG2 (SETS_LOG2),
            .TAG_W     (TAG_W),
            .PPN_W     (PPN_W)
        ) u_arr (
            .clk      (clk),
            .rst_n    (rst_n),
            .flush    (flush),
            .lk_en    (lk_go && (req_side == g[0])),
            .lk_set   (req_set),
            .lk_tag   (req_vpn),
            .lk_c_ok  (c_ok),
            .lk_hit   (arr_hit[g]),
            .lk_cneed (arr_cneed[g]),
            .lk_ppn   (arr_ppn[g]),
            .lk_wi    (arr_wi[g]),
            .fill_en  (fill_go && (fill_side == g[0])),
            .fill_set (fill_set),
            .fill_tag (fill_vpn),
            .fill_pte (fill_pte)
        );
    end

    always_comb begin
        sel_hit   = lk_go && arr_hit[req_side];
        sel_cneed = lk_go && arr_cneed[req_side];
        rsp_d     = rsp_q;
        rsp_d.valid = req_valid;
        if (req_valid) begin
            rsp_d.hit   = sel_hit && !sel_cneed;
            rsp_d.updc  = sel_cneed;
            rsp_d.paddr = (sel_hit && !sel_cneed) ?
                          {arr_ppn[req_side], req_addr[PAGE_SHIFT-1:0]} : '0;
            rsp_d.wi    = sel_hit && !sel_cneed && arr_wi[req_side];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_hit   = rsp_q.hit;
    assign rsp_upd_c = rsp_q.updc;
    assign rsp_paddr = rsp_q.paddr;
    assign rsp_wi    = rsp_q.wi;

    assert_timing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !(rsp_hit && rsp_upd_c));

    assert_noexc_no_c_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_noexc) |=> !rsp_upd_c);

    assert_offset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !flush) |=> (!rsp_hit || rsp_paddr[PAGE_SHIFT-1:0] == $past(req_addr[PAGE_SHIFT-1:0])));

    assert_flush_miss_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && flush) |=> (!rsp_hit && !rsp_upd_c));
endmodule

// File: tb/tlb2w_top_bench.sv
`timescale 1ns/1ps
module tlb2w_top_bench;
    localparam int SL = 2;
    localparam int NS = 1 << SL;

    logic clk = 0, rst_n = 0, flush = 0;
    logic req_valid = 0, req_noexc = 0, fill_valid = 0, fill_noexc = 0;
    logic [31:0] req_addr = 0, fill_pte = 0;
    logic [19:0] fill_vpn = 0;
    logic [1:0]  req_op = 0, fill_op = 0;
    logic rsp_valid, rsp_hit, rsp_upd_c, rsp_wi;
    logic [31:0] rsp_paddr;

    int checks = 0, errors = 0;

    logic [19:0] m_tag [2][NS][2];
    logic [31:0] m_pte [2][NS][2];
    logic        m_rec [2][NS];
    logic        m_last_c;
    logic [31:0] lfsr = 32'h1234_5678;

    always #2 clk = ~clk;

    tlb2w_top #(.VA_W(32), .PAGE_SHIFT(12), .SETS_LOG2(SL)) u_tlb2w_top (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .req_valid(req_valid), .req_addr(req_addr), .req_op(req_op), .req_noexc(req_noexc),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_op(fill_op),
        .fill_noexc(fill_noexc), .fill_pte(fill_pte),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_upd_c(rsp_upd_c),
        .rsp_paddr(rsp_paddr), .rsp_wi(rsp_wi)
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rnd();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        return lfsr;
    endfunction

    function automatic logic [31:0] mk_pte(input logic [19:0] vpn, input logic cbit);
        logic [19:0] ppn = vpn ^ 20'h5A3C1;
        return {ppn, 3'b000, 1'b1, cbit, vpn[3:0], 1'b0, vpn[1:0]};
    endfunction

    task automatic model_reset();
        for (int s = 0; s < 2; s++)
            for (int i = 0; i < NS; i++) begin
                m_rec[s][i] = 0;
                for (int w = 0; w < 2; w++) begin
                    m_tag[s][i][w] = '1;
                    m_pte[s][i][w] = 0;
                end
            end
        m_last_c = 0;
    endtask

    // one cycle: optional lookup, optional refill, optional flush
    task automatic step(input string ctx, input logic lv, input logic [31:0] addr,
                        input logic [1:0] op, input logic nx,
                        input logic fv, input logic [19:0] fvpn, input logic [1:0] fop,
                        input logic fnx, input logic [31:0] pte, input logic fl);
        logic side, fside, fgo, blocked, w0, w1, way, e_hit, e_c, e_wi;
        logic [19:0] vpn;
        logic [SL-1:0] set, fset;
        logic [31:0] e_pa;
        int v;
        @(negedge clk);
        req_valid = lv; req_addr = addr; req_op = op; req_noexc = nx;
        fill_valid = fv; fill_vpn = fvpn; fill_op = fop; fill_noexc = fnx; fill_pte = pte;
        flush = fl;
        vpn = addr[31:12]; set = vpn[SL-1:0]; side = (op == 2);
        fset = fvpn[SL-1:0]; fside = (fop == 2);
        fgo = fv && !fnx && !m_last_c && !fl;
        blocked = fgo && (fside == side) && (fset == set);
        e_hit = 0; e_c = 0; e_pa = 0; e_wi = 0;
        if (lv && !fl && !blocked) begin
            w0 = (m_tag[side][set][0] == vpn) && (vpn != '1);
            w1 = (m_tag[side][set][1] == vpn) && (vpn != '1);
            way = !w0;
            if (w0 || w1) begin
                if (op == 1 && !nx && !m_pte[side][set][way][7]) begin
                    e_c = 1;
                    m_pte[side][set][way][7] = 1'b1;
                end else begin
                    e_hit = 1;
                    m_rec[side][set] = way;
                    e_pa = {m_pte[side][set][way][31:12], addr[11:0]};
                    e_wi = m_pte[side][set][way][6] | m_pte[side][set][way][5];
                end
            end
        end
        if (fgo) begin
            v = (!m_rec[fside][fset] && m_tag[fside][fset][0] != '1) ? 1 : 0;
            m_tag[fside][fset][v] = fvpn;
            m_pte[fside][fset][v] = pte;
            m_rec[fside][fset] = v[0];
        end
        if (fl)
            for (int s = 0; s < 2; s++)
                for (int i = 0; i < NS; i++) begin
                    m_tag[s][i][0] = '1; m_tag[s][i][1] = '1;
                end
        if (lv) m_last_c = e_c;
        @(negedge clk);
        req_valid = 0; fill_valid = 0; flush = 0;
        chk(rsp_valid == lv, {ctx, " R2 valid"}, {31'b0, rsp_valid}, {31'b0, lv});
        if (lv) begin
            chk(rsp_hit == e_hit, {ctx, " R2 hit"}, {31'b0, rsp_hit}, {31'b0, e_hit});
            chk(rsp_upd_c == e_c, {ctx, " R5 upd_c"}, {31'b0, rsp_upd_c}, {31'b0, e_c});
            chk(rsp_paddr == e_pa, {ctx, " R3 paddr"}, rsp_paddr, e_pa);
            chk(rsp_wi == e_wi, {ctx, " R6 wi"}, {31'b0, rsp_wi}, {31'b0, e_wi});
        end
    endtask

    task automatic look(input string ctx, input logic [19:0] vpn, input logic [1:0] op, input logic nx);
        step(ctx, 1, {vpn, 12'h9A7 ^ {2'b0, vpn[9:0]}}, op, nx, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic put(input string ctx, input logic [19:0] vpn, input logic [1:0] op, input logic nx, input logic [31:0] pte);
        step(ctx, 0, 0, 0, 0, 1, vpn, op, nx, pte, 0);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset outputs
        chk({rsp_valid, rsp_hit, rsp_upd_c, rsp_wi} == 4'b0, "R1 reset flags", {28'b0, rsp_valid, rsp_hit, rsp_upd_c, rsp_wi}, 0);
        chk(rsp_paddr == 0, "R1 reset paddr", rsp_paddr, 0);
        for (int v = 0; v < 16; v++) begin
            look("R1 empty data", v[19:0], 0, 0);
            look("R1 empty fetch", v[19:0], 2, 0);
        end

        // fill sweep with evictions, both arrays
        for (int s = 0; s < 2; s++)
            for (int k = 0; k < 4; k++) begin
                for (int i = 0; i < NS; i++)
                    put("R7 sweep", 20'(i + NS * k + 64 * s), s ? 2'd2 : 2'd0, 0,
                        mk_pte(20'(i + NS * k + 64 * s), 1'b1));
                for (int v = 0; v < 16; v++)
                    look("R7 sweep", 20'(v + 64 * s), s ? 2'd2 : 2'd3, 0);
            end

        // R4 separation
        flush_cycle();
        put("R4", 20'h00011, 0, 0, mk_pte(20'h00011, 1));
        look("R4 fetch other array", 20'h00011, 2, 0);
        look("R4 data array", 20'h00011, 0, 0);

        // R7 directed replacement in set 0
        flush_cycle();
        put("R7", 20'h00100, 0, 0, mk_pte(20'h00100, 1));
        put("R7", 20'h00104, 0, 0, mk_pte(20'h00104, 1));
        put("R7", 20'h00108, 0, 0, mk_pte(20'h00108, 1));
        look("R7 evicted", 20'h00100, 0, 0);
        look("R7 way1", 20'h00104, 0, 0);
        put("R7", 20'h0010C, 0, 0, mk_pte(20'h0010C, 1));
        look("R7 evicted way0", 20'h00108, 0, 0);
        look("R7 kept way1", 20'h00104, 0, 0);

        // R5 / R8 / R9 changed bit
        put("R5", 20'h00201, 0, 0, mk_pte(20'h00201, 0));
        look("R5 read no C", 20'h00201, 0, 0);
        look("R8 noexc write", 20'h00201, 1, 1);
        look("R5 write sets C", 20'h00201, 1, 0);
        put("R9 fill dropped", 20'h00305, 0, 0, mk_pte(20'h00305, 1));
        look("R9 check", 20'h00305, 0, 0);
        look("R5 second write", 20'h00201, 1, 0);
        put("R8 noexc fill", 20'h00306, 0, 1, mk_pte(20'h00306, 1));
        look("R8 check", 20'h00306, 0, 0);

        // R10 clash
        put("R10", 20'h00402, 0, 0, mk_pte(20'h00402, 1));
        step("R10 same set", 1, {20'h00402, 12'h123}, 0, 0, 1, 20'h00406, 0, 0, mk_pte(20'h00406, 1), 0);
        step("R10 other set", 1, {20'h00402, 12'h456}, 0, 0, 1, 20'h00407, 0, 0, mk_pte(20'h00407, 1), 0);
        look("R10 fill landed", 20'h00406, 0, 0);

        // R11 flush with lookup and fill in the same cycle
        step("R11 flush cycle", 1, {20'h00402, 12'h0}, 0, 0, 1, 20'h00409, 0, 0, mk_pte(20'h00409, 1), 1);
        look("R11 after flush", 20'h00406, 0, 0);
        look("R11 dropped fill", 20'h00409, 0, 0);

        // pseudo-random mix
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r, q;
            r = rnd(); q = rnd();
            step("R2 mix", r[0] | r[1], {12'b0, r[7:3], 3'b0, r[31:20]}, r[9:8], r[10] & r[11],
                 r[12] | r[13], {15'b0, q[4:0]}, q[6:5], q[7] & q[8],
                 {q[31:12], 3'b0, 1'b1, q[9], q[14:11], 1'b0, q[16:15]},
                 (q[19:17] == 0) && (r[14] & r[15]));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic flush_cycle();
        step("R11 flush", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    endtask
endmodule